// File: doc/BRIEF.md
# Receive Packet FIFO With Rollback

This block buffers the data packets that a device endpoint receives from the host. The packet engine pushes each byte into the FIFO while the packet is still arriving, before the packet's CRC has been checked. When the packet ends, the engine sends one strobe that carries the CRC verdict and the data toggle (DATA0 or DATA1) seen in the packet's PID. The FIFO then keeps the whole packet or removes all of it.

Inside, two write pointers run side by side. A tentative pointer moves on every stored byte. A committed pointer marks the end of the data the application is allowed to read. On a good packet the tentative pointer is copied into the committed one. On a bad CRC, a toggle mismatch (a repeat of a packet already accepted) or an overflow, the tentative pointer is set back to the committed one. A resent packet is then stored from the same start position. The writer sees fullness measured from the tentative pointer. The reader sees emptiness and level measured from the committed pointer.

An expected-toggle bit flips each time a packet is committed. A clear input sets it back to DATA0. The write side is a three-state machine: `WS_IDLE` means no packet is in progress, `WS_RECV` means bytes of the current packet are being stored, and `WS_OVFL` means a write was attempted while full. Its transitions are:
- `start`: `WS_IDLE` to `WS_RECV` on an accepted write.
- `fill_up`: `WS_IDLE` or `WS_RECV` to `WS_OVFL` on a write while full.
- `finish`: any state to `WS_IDLE` on the end strobe.
- `hold`: any other cycle stays in the current state.

`DEPTH` must be a power of two and at least as large as the 64-byte maximum packet.

Top module: `rx_pkt_fifo`

## Requirements
- R1: While reset is held and directly after it, `empty`=1, `level`=0, `full`=0, `overflow`=0 and `exp_toggle`=0 (DATA0).
- R2: Bytes of a packet that is still arriving are not visible to the reader: `level` does not rise before the end strobe. A good packet becomes readable in the cycle after its end strobe. A good packet has `end_crc_ok`=1, `end_pid_data1` equal to `exp_toggle`, and no overflow. At that point `level` has grown by its length.
- R3: A packet ended with `end_crc_ok`=0 leaves `level` unchanged. None of its bytes can ever be read. A resend of that packet is stored from the same position and reads back correctly.
- R4: A packet whose toggle (`end_pid_data1`: 0=DATA0, 1=DATA1) differs from `exp_toggle` is discarded as a duplicate. `exp_toggle` is left unchanged.
- R5: `exp_toggle` inverts in the cycle after each committed packet, and this includes a zero-length packet. It does not change on a discarded packet.
- R6: `tog_clear`=1 forces `exp_toggle` to 0 in the next cycle, and this takes priority over a flip from a commit in the same cycle.
- R7: `full`=1 exactly when unread committed bytes plus uncommitted bytes equal `DEPTH`. This counts bytes of a packet not yet committed.
- R8: A write while `full`=1 is not stored and sets `overflow`=1. It stays at 1 until the end strobe, the packet is then discarded even if its CRC and toggle are good, and `overflow` returns to 0 in the next cycle.
- R9: `rd_data` always shows the oldest committed unread byte. `rd_en`=1 with `empty`=0 removes one byte, and `rd_en`=1 with `empty`=1 has no effect.
- R10: A write in the same cycle as the end strobe is dropped. It is not part of that packet.
- R11: `level` equals the number of committed unread bytes, lies in 0..`DEPTH`, and `empty`=1 exactly when `level`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tog_clear | input | 1 | Sets the expected toggle to DATA0 |
| wr_en | input | 1 | Byte write strobe from the packet engine |
| wr_data | input | DATA_W | Received byte |
| full | output | 1 | No room for another byte (tentative pointer) |
| overflow | output | 1 | The current packet hit a full FIFO |
| end_strobe | input | 1 | End of packet |
| end_crc_ok | input | 1 | CRC of the ending packet was good |
| end_pid_data1 | input | 1 | Toggle of the ending packet: 0=DATA0, 1=DATA1 |
| exp_toggle | output | 1 | Toggle expected for the next new packet |
| rd_en | input | 1 | Pop one byte |
| rd_data | output | DATA_W | Oldest committed byte (first-word fall-through) |
| empty | output | 1 | No committed byte to read |
| level | output | clog2(DEPTH)+1 | Number of committed unread bytes |

## Verification
Several properties are checked on every cycle:
- A bad or discarded packet never raises `level`.
- `level` never rises while a packet is still arriving.
- A duplicate leaves the toggle alone, and a clear forces it low.
- A write while full raises `overflow`, and the end strobe clears it.
- `empty` agrees with `level`.

Only the bench scenarios can show what needs byte order and history:
- Committed bytes read back in order.
- A resend after a bad CRC overwrites the abandoned bytes correctly.
- `full` reflects bytes that are not yet committed.
- A write in the end-strobe cycle really is left out.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // Write-side packet state
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_RECV = 2'd1,
        WS_OVFL = 2'd2
    } wr_state_e;

    // End-of-packet decision
    typedef enum logic [1:0] {
        DEC_NONE   = 2'd0,
        DEC_COMMIT = 2'd1,
        DEC_DROP   = 2'd2
    } end_dec_e;

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [DATA_W-1:0]        rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tog_clear,
    input  logic                     wr_en,
    input  logic                     end_strobe,
    input  logic                     end_crc_ok,
    input  logic                     end_pid_data1,
    input  logic [$clog2(DEPTH):0]   rptr,
    output logic                     mem_we,
    output logic [$clog2(DEPTH)-1:0] mem_waddr,
    output logic [$clog2(DEPTH):0]   wptr_c,
    output logic                     full,
    output logic                     overflow,
    output logic                     exp_toggle
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    wr_state_e   state, state_nx;
    end_dec_e    dec;
    logic [AW:0] wptr_s;
    logic [AW:0] occ_s;

    // Fullness is measured from the tentative pointer
    assign occ_s = wptr_s - rptr;
    assign full  = (occ_s == DEPTH_V);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WS_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            WS_IDLE: begin
                if (end_strobe)          state_nx = WS_IDLE;
                else if (wr_en && full)  state_nx = WS_OVFL;
                else if (wr_en)          state_nx = WS_RECV;
            end
            WS_RECV: begin
                if (end_strobe)          state_nx = WS_IDLE;
                else if (wr_en && full)  state_nx = WS_OVFL;
            end
            WS_OVFL: begin
                if (end_strobe)          state_nx = WS_IDLE;
            end
            default:                     state_nx = WS_IDLE;
        endcase
    end

    // Outputs and decision
    always_comb begin
        overflow = 1'b0;
        mem_we   = 1'b0;
        dec      = DEC_NONE;
        unique case (state)
            WS_IDLE, WS_RECV: begin
                mem_we = wr_en && !full && !end_strobe;
                if (end_strobe) begin
                    dec = (end_crc_ok && (end_pid_data1 == exp_toggle))
                          ? DEC_COMMIT : DEC_DROP;
                end
            end
            WS_OVFL: begin
                overflow = 1'b1;
                if (end_strobe) dec = DEC_DROP;
            end
            default: dec = DEC_NONE;
        endcase
    end

    assign mem_waddr = wptr_s[AW-1:0];

    // Tentative and committed pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_s <= '0;
            wptr_c <= '0;
        end else begin
            unique case (dec)
                DEC_COMMIT: wptr_c <= wptr_s;
                DEC_DROP:   wptr_s <= wptr_c;
                default: begin
                    if (mem_we) wptr_s <= wptr_s + 1'b1;
                end
            endcase
        end
    end

    // Expected data toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_toggle <= 1'b0;
        end else if (tog_clear) begin
            exp_toggle <= 1'b0;
        end else if (dec == DEC_COMMIT) begin
            exp_toggle <= ~exp_toggle;
        end
    end
endmodule

// File: rtl/rxf_rd_ctrl.sv
module rxf_rd_ctrl #(
    parameter int DEPTH = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH):0]   wptr_c,
    output logic [$clog2(DEPTH):0]   rptr,
    output logic [$clog2(DEPTH)-1:0] raddr,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);

    logic pop;

    assign level = wptr_c - rptr;
    assign empty = (wptr_c == rptr);
    assign pop   = rd_en && !empty;
    assign raddr = rptr[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr <= '0;
        end else if (pop) begin
            rptr <= rptr + 1'b1;
        end
    end
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tog_clear,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     full,
    output logic                     overflow,
    input  logic                     end_strobe,
    input  logic                     end_crc_ok,
    input  logic                     end_pid_data1,
    output logic                     exp_toggle,
    input  logic                     rd_en,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     empty,
    output logic [$clog2(DEPTH):0]   level
);
    localparam int AW = $clog2(DEPTH);

    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    logic [AW-1:0] mem_raddr;
    logic [AW:0]   wptr_c;
    logic [AW:0]   rptr;

    rxf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk           (clk),
        .rst_n         (rst_n),
        .tog_clear     (tog_clear),
        .wr_en         (wr_en),
        .end_strobe    (end_strobe),
        .end_crc_ok    (end_crc_ok),
        .end_pid_data1 (end_pid_data1),
        .rptr          (rptr),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .wptr_c        (wptr_c),
        .full          (full),
        .overflow      (overflow),
        .exp_toggle    (exp_toggle)
    );

    rxf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (rd_en),
        .wptr_c (wptr_c),
        .rptr   (rptr),
        .raddr  (mem_raddr),
        .empty  (empty),
        .level  (level)
    );

    rxf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk #(
    parameter int DEPTH = 128
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tog_clear,
    input logic                   wr_en,
    input logic                   full,
    input logic                   overflow,
    input logic                   end_strobe,
    input logic                   end_crc_ok,
    input logic                   end_pid_data1,
    input logic                   exp_toggle,
    input logic                   empty,
    input logic [$clog2(DEPTH):0] level
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

    assert_empty_matches_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (level == '0));

    assert_level_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_V);

    assert_no_early_visibility_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !end_strobe |=> level <= $past(level));

    assert_bad_crc_no_growth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (end_strobe && !end_crc_ok) |=> level <= $past(level));

    assert_dup_keeps_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (end_strobe && (end_pid_data1 != exp_toggle) && !tog_clear) |=> $stable(exp_toggle));

    assert_commit_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (end_strobe && end_crc_ok && (end_pid_data1 == exp_toggle) && !overflow && !tog_clear)
        |=> (exp_toggle != $past(exp_toggle)));

    assert_clear_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tog_clear |=> !exp_toggle);

    assert_no_overflow_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !end_strobe) |=> overflow);

    assert_overflow_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        end_strobe |=> !overflow);
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tog_clear     (tog_clear),
    .wr_en         (wr_en),
    .full          (full),
    .overflow      (overflow),
    .end_strobe    (end_strobe),
    .end_crc_ok    (end_crc_ok),
    .end_pid_data1 (end_pid_data1),
    .exp_toggle    (exp_toggle),
    .empty         (empty),
    .level         (level)
);

// File: tb/test_rx_pkt_fifo.sv
`timescale 1ns/1ps
module test_rx_pkt_fifo;
    localparam int DW = 8;
    localparam int DEPTH = 16;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tog_clear = 1'b0;
    logic wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic full, overflow, exp_toggle, empty;
    logic end_strobe = 1'b0, end_crc_ok = 1'b0, end_pid_data1 = 1'b0;
    logic rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic [AW:0] level;

    int checks = 0;
    int failures = 0;
    logic model_tog = 1'b0;

    always #5 clk = ~clk;

    rx_pkt_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_rx_pkt_fifo (
        .clk(clk), .rst_n(rst_n), .tog_clear(tog_clear),
        .wr_en(wr_en), .wr_data(wr_data), .full(full), .overflow(overflow),
        .end_strobe(end_strobe), .end_crc_ok(end_crc_ok), .end_pid_data1(end_pid_data1),
        .exp_toggle(exp_toggle), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .level(level)
    );

    function automatic logic [DW-1:0] pat(input int seed, input int i);
        return DW'(seed * 37 + i * 11 + 5);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write len bytes, then send the end strobe; returns at a negedge after commit/drop
    task automatic send_pkt(input int len, input int seed, input logic crc, input logic pid,
                            input logic wr_at_end, input logic clr_at_end);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = pat(seed, i);
        end
        @(negedge clk);
        if (len > 0) begin
            chk(level == '0, "R2 level before end strobe", int'(level), 0);
        end
        wr_en = wr_at_end;
        wr_data = 8'hEE;
        end_strobe = 1'b1;
        end_crc_ok = crc;
        end_pid_data1 = pid;
        tog_clear = clr_at_end;
        @(negedge clk);
        wr_en = 1'b0;
        end_strobe = 1'b0;
        tog_clear = 1'b0;
    endtask

    task automatic drain(input int len, input int seed, input string req);
        for (int i = 0; i < len; i++) begin
            chk(rd_data == pat(seed, i), req, int'(rd_data), int'(pat(seed, i)));
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(empty == 1'b1, "R11 empty after drain", int'(empty), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(empty == 1'b1, "R1 empty in reset", int'(empty), 1);
        chk(level == '0, "R1 level in reset", int'(level), 0);
        chk(full == 1'b0 && overflow == 1'b0, "R1 full/overflow in reset", int'({full, overflow}), 0);
        chk(exp_toggle == 1'b0, "R1 toggle in reset", int'(exp_toggle), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(empty == 1'b1 && level == '0, "R1 state after reset", int'(level), 0);

        // Sweep length x CRC x toggle
        for (int len = 0; len <= 10; len++) begin
            for (int mode = 0; mode < 4; mode++) begin
                logic crc, pidv, commit;
                int seed;
                seed = len * 4 + mode;
                crc = mode[0];
                pidv = mode[1] ? model_tog : ~model_tog;
                commit = crc && (pidv == model_tog);
                send_pkt(len, seed, crc, pidv, 1'b0, 1'b0);
                if (commit) begin
                    model_tog = ~model_tog;
                    chk(int'(level) == len, "R2 level after good packet", int'(level), len);
                    chk(exp_toggle == model_tog, "R5 toggle flips on commit", int'(exp_toggle), int'(model_tog));
                    drain(len, seed, "R2 committed data order");
                end else begin
                    chk(level == '0, crc ? "R4 duplicate discarded" : "R3 bad packet discarded",
                        int'(level), 0);
                    chk(exp_toggle == model_tog, crc ? "R4 toggle kept on duplicate" : "R5 toggle kept on drop",
                        int'(exp_toggle), int'(model_tog));
                    if (!crc) begin
                        // R3 resend from same position, different bytes overwrite
                        send_pkt(len, seed + 100, 1'b1, model_tog, 1'b0, 1'b0);
                        model_tog = ~model_tog;
                        chk(int'(level) == len, "R3 resend committed", int'(level), len);
                        drain(len, seed + 100, "R3 resend data");
                    end
                end
            end
        end

        // R9 read while empty has no effect
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(level == '0 && empty == 1'b1, "R9 read while empty ignored", int'(level), 0);

        // R7 full counts uncommitted bytes
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_data = pat(77, i);
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk(full == 1'b1, "R7 full from uncommitted bytes", int'(full), 1);
        chk(level == '0, "R7 nothing committed yet", int'(level), 0);
        end_strobe = 1'b1; end_crc_ok = 1'b1; end_pid_data1 = model_tog;
        @(negedge clk);
        end_strobe = 1'b0;
        model_tog = ~model_tog;
        chk(int'(level) == DEPTH, "R11 level reaches DEPTH", int'(level), DEPTH);
        chk(full == 1'b1, "R7 full with committed data", int'(full), 1);

        // R8 write while full -> overflow, then drop despite good CRC/toggle
        wr_en = 1'b1; wr_data = 8'h5A;
        @(negedge clk);
        wr_en = 1'b0;
        chk(overflow == 1'b1, "R8 overflow raised", int'(overflow), 1);
        rd_en = 1'b1;           // free one slot; overflow must persist
        @(negedge clk);
        rd_en = 1'b0;
        chk(overflow == 1'b1, "R8 overflow held", int'(overflow), 1);
        end_strobe = 1'b1; end_crc_ok = 1'b1; end_pid_data1 = model_tog;
        @(negedge clk);
        end_strobe = 1'b0;
        chk(overflow == 1'b0, "R8 overflow cleared", int'(overflow), 0);
        chk(int'(level) == DEPTH - 1, "R8 overflowed packet dropped", int'(level), DEPTH - 1);
        chk(exp_toggle == model_tog, "R8 toggle kept", int'(exp_toggle), int'(model_tog));
        for (int i = 1; i < DEPTH; i++) begin
            chk(rd_data == pat(77, i), "R9 data after overflow", int'(rd_data), int'(pat(77, i)));
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
        chk(empty == 1'b1 && full == 1'b0, "R11 empty after full drain", int'(empty), 1);

        // R10 write in end-strobe cycle dropped
        send_pkt(3, 55, 1'b1, model_tog, 1'b1, 1'b0);
        model_tog = ~model_tog;
        chk(level == 3, "R10 end-cycle write dropped", int'(level), 3);
        drain(3, 55, "R10 data");

        // R6 clear toggle, including priority over a commit flip
        if (model_tog == 1'b0) begin
            send_pkt(0, 0, 1'b1, 1'b0, 1'b0, 1'b0);
            model_tog = 1'b1;
        end
        chk(exp_toggle == 1'b1, "R5 toggle at DATA1 before clear", int'(exp_toggle), 1);
        @(negedge clk);
        tog_clear = 1'b1;
        @(negedge clk);
        tog_clear = 1'b0;
        chk(exp_toggle == 1'b0, "R6 clear to DATA0", int'(exp_toggle), 0);
        send_pkt(2, 9, 1'b1, 1'b0, 1'b0, 1'b1);
        chk(exp_toggle == 1'b0, "R6 clear beats commit flip", int'(exp_toggle), 0);
        chk(level == 2, "R6 packet still committed", int'(level), 2);
        drain(2, 9, "R6 data");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule